// File: doc/BRIEF.md
# Flagless Barrel Shift and Rotate Unit

A purely combinational barrel unit over a configurable data width (64 bits by default). It performs one of four operations on a data word: logical shift right, arithmetic shift right, shift left, or rotate right. A two-bit operation select chooses the operation. The unit has no status outputs. It neither computes nor passes through any carry, zero, sign or overflow indication, so an execution pipeline can place it in a slot that never touches the flags.

The two count sources differ by operation. The three shifts take their count from a register-width operand. The rotate takes its count from an immediate byte. Only the low log2(WIDTH) bits of the selected count are used. An effective count of zero returns the data word unchanged.

Top module: `shx_unit`

## Requirements
- R1: For the shifts, only bits [5:0] of `reg_count` form the effective count. Setting any of bits [31:6] leaves `result` unchanged.
- R2: For the rotate (op 2'b11), the effective count is `imm_count[5:0]`. Bits [7:6] of `imm_count` and all of `reg_count` have no effect on `result`.
- R3: For the three shifts (op 2'b00, 2'b01, 2'b10), `imm_count` has no effect on `result`.
- R4: An effective count of zero gives `result == data_in` for every operation.
- R5: Op 2'b00 (logical right) gives `data_in >> n` and fills the vacated upper bits with zeros.
- R6: Op 2'b01 (arithmetic right) gives `data_in >> n` and fills the vacated upper bits with copies of `data_in[63]`.
- R7: Op 2'b10 (left) gives `data_in << n` and fills the vacated lower bits with zeros.
- R8: Op 2'b11 (rotate right) gives `(data_in >> n) | (data_in << (64-n))` for non-zero n. The number of set bits is preserved.
- R9: `result` is a combinational function of the present inputs only, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | 00 logical right, 01 arithmetic right, 10 left, 11 rotate right |
| data_in | input | 64 | Word to shift or rotate |
| reg_count | input | 32 | Register count operand, used by the shifts |
| imm_count | input | 8 | Immediate count, used by the rotate |
| result | output | 64 | Shifted or rotated word |

## Verification
The bench builds the unit with its default parameters: a 64-bit word, a 32-bit register count, an 8-bit immediate and the logarithmic stage chain. With these values every effective count from 0 to 63 can be swept for each operation, and the count bits above bit 5 exist and can be driven. This exposes masking faults and faults in the selection between the register and immediate count sources. Sign fill is checked with words whose top bit is both set and clear.

// File: rtl/shx_pkg.sv
package shx_pkg;
   typedef enum logic [1:0] {
      SHX_LSR = 2'b00,
      SHX_ASR = 2'b01,
      SHX_LSL = 2'b10,
      SHX_ROR = 2'b11
   } shx_op_e;
endpackage

// File: rtl/shx_count_sel.sv
// Picks the count source by operation and keeps only the low CNT_W bits.
module shx_count_sel #(
   parameter int CNT_W = 6,
   parameter int REG_W = 32,
   parameter int IMM_W = 8
) (
   input  logic [1:0]       op_sel,
   input  logic [REG_W-1:0] reg_cnt,
   input  logic [IMM_W-1:0] imm_cnt,
   output logic [CNT_W-1:0] cnt
);
   import shx_pkg::*;

   logic unused_hi_bits;
   assign unused_hi_bits = ^{reg_cnt[REG_W-1:CNT_W], imm_cnt[IMM_W-1:CNT_W]};

   always_comb begin
      if (shx_op_e'(op_sel) == SHX_ROR) cnt = imm_cnt[CNT_W-1:0];
      else                              cnt = reg_cnt[CNT_W-1:0];
   end
endmodule

// File: rtl/shx_rot_right.sv
// Right rotator; LOG_STAGES picks a staged mux chain or a doubled-word shift.
module shx_rot_right #(
   parameter int WIDTH      = 64,
   parameter int CNT_W      = 6,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [WIDTH-1:0] din,
   input  logic [CNT_W-1:0] cnt,
   output logic [WIDTH-1:0] dout
);
   generate
      if (LOG_STAGES) begin : g_stages
         logic [WIDTH-1:0] stg [CNT_W+1];
         assign stg[0] = din;
         for (genvar s = 0; s < CNT_W; s++) begin : g_stage
            localparam int AMT = 1 << s;
            assign stg[s+1] = cnt[s] ? {stg[s][AMT-1:0], stg[s][WIDTH-1:AMT]}
                                     : stg[s];
         end
         assign dout = stg[CNT_W];
      end else begin : g_direct
         logic [2*WIDTH-1:0] dbl;
         assign dbl  = {din, din} >> cnt;
         assign dout = dbl[WIDTH-1:0];
      end
   endgenerate
endmodule

// File: rtl/shx_keep_mask.sv
// Bit i is kept after a right move by cnt when i + cnt < WIDTH.
module shx_keep_mask #(
   parameter int WIDTH = 64,
   parameter int CNT_W = 6
) (
   input  logic [CNT_W-1:0] cnt,
   output logic [WIDTH-1:0] keep
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         localparam int ROOM = WIDTH - 1 - i;
         assign keep[i] = (cnt <= CNT_W'(ROOM));
      end
   endgenerate
endmodule

// File: rtl/shx_unit.sv
module shx_unit #(
   parameter int WIDTH      = 64,
   parameter int REG_W      = 32,
   parameter int IMM_W      = 8,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [1:0]       op_sel,
   input  logic [WIDTH-1:0] data_in,
   input  logic [REG_W-1:0] reg_count,
   input  logic [IMM_W-1:0] imm_count,
   output logic [WIDTH-1:0] result
);
   import shx_pkg::*;

   localparam int CNT_W = $clog2(WIDTH);

   generate
      if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("shx_unit: WIDTH must be a power of two of at least 2");
      end
      if (REG_W <= CNT_W || IMM_W <= CNT_W) begin : g_bad_cnt
         $error("shx_unit: count operands must be wider than the count field");
      end
   endgenerate

   shx_op_e          op;
   logic [CNT_W-1:0] cnt;
   logic [WIDTH-1:0] src, src_rev, rot, keep, moved, moved_rev, fill;
   logic             is_left;

   assign op      = shx_op_e'(op_sel);
   assign is_left = (op == SHX_LSL);

   shx_count_sel #(.CNT_W(CNT_W), .REG_W(REG_W), .IMM_W(IMM_W)) u_cnt (
      .op_sel (op_sel),
      .reg_cnt(reg_count),
      .imm_cnt(imm_count),
      .cnt    (cnt)
   );

   // A left shift is a right shift of the bit-reversed word, reversed back.
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_rev
         assign src_rev[i]   = data_in[WIDTH-1-i];
         assign moved_rev[i] = moved[WIDTH-1-i];
      end
   endgenerate

   assign src = is_left ? src_rev : data_in;

   shx_rot_right #(.WIDTH(WIDTH), .CNT_W(CNT_W), .LOG_STAGES(LOG_STAGES)) u_rot (
      .din (src),
      .cnt (cnt),
      .dout(rot)
   );

   shx_keep_mask #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_mask (
      .cnt (cnt),
      .keep(keep)
   );

   assign fill  = (op == SHX_ASR) ? {WIDTH{data_in[WIDTH-1]}} : '0;
   assign moved = (rot & keep) | (fill & ~keep);

   always_comb begin
      unique case (op)
         SHX_ROR: result = rot;
         SHX_LSL: result = moved_rev;
         default: result = moved;
      endcase
   end
endmodule

// File: rtl/shx_unit_chk.sv
module shx_unit_chk #(
   parameter int WIDTH = 64,
   parameter int REG_W = 32,
   parameter int IMM_W = 8
) (
   input logic [1:0]       op_sel,
   input logic [WIDTH-1:0] data_in,
   input logic [REG_W-1:0] reg_count,
   input logic [IMM_W-1:0] imm_count,
   input logic [WIDTH-1:0] result
);
   localparam int CNT_W = $clog2(WIDTH);

   logic [CNT_W-1:0] n;
   always_comb begin
      n = (op_sel == 2'b11) ? imm_count[CNT_W-1:0] : reg_count[CNT_W-1:0];
      if (n == '0) begin
         p_zero_pass_r4: assert (result == data_in)
            else $error("zero count altered the word");
      end else begin
         if (op_sel == 2'b00) begin
            p_lsr_top_zero_r5: assert (result[WIDTH-1] == 1'b0)
               else $error("logical right left a high bit set");
         end
         if (op_sel == 2'b10) begin
            p_lsl_low_zero_r7: assert (result[0] == 1'b0)
               else $error("left shift left a low bit set");
         end
      end
      if (op_sel == 2'b01) begin
         p_asr_sign_r6: assert (result[WIDTH-1] == data_in[WIDTH-1])
            else $error("arithmetic right lost the sign");
      end
      if (op_sel == 2'b11) begin
         p_ror_ones_r8: assert ($countones(result) == $countones(data_in))
            else $error("rotate changed the population count");
      end
   end
endmodule

bind shx_unit shx_unit_chk #(.WIDTH(WIDTH), .REG_W(REG_W), .IMM_W(IMM_W)) u_chk (
   .op_sel   (op_sel),
   .data_in  (data_in),
   .reg_count(reg_count),
   .imm_count(imm_count),
   .result   (result)
);

// File: tb/shx_unit_bench.sv
module shx_unit_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [1:0]  op_sel;
   logic [63:0] data_in;
   logic [31:0] reg_count;
   logic [7:0]  imm_count;
   logic [63:0] result;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   shx_unit u_shx_unit (
      .op_sel   (op_sel),
      .data_in  (data_in),
      .reg_count(reg_count),
      .imm_count(imm_count),
      .result   (result)
   );

   function automatic logic [63:0] ref_out(input logic [1:0] op,
                                           input logic [63:0] d,
                                           input int n);
      if (n == 0) return d;
      case (op)
         2'b00:   return d >> n;
         2'b01:   return 64'($signed(d) >>> n);
         2'b10:   return d << n;
         default: return (d >> n) | (d << (64 - n));
      endcase
   endfunction

   task automatic apply(input logic [1:0] op, input logic [63:0] d,
                        input logic [31:0] rc, input logic [7:0] ic,
                        input logic [63:0] exp, input string req);
      @(negedge clk);
      op_sel = op; data_in = d; reg_count = rc; imm_count = ic;
      #3;
      checks++;
      if (result !== exp) begin
         fails++;
         $display("FAIL %s op=%b data=%h rc=%h ic=%h got=%h exp=%h",
                  req, op, d, rc, ic, result, exp);
      end
   endtask

   // Idle inputs after reset give a zero word (R4, zero data).
   task automatic t_idle;
      apply(2'b00, 64'h0, 32'h0, 8'h0, 64'h0, "R4 idle");
   endtask

   // Every count on several patterns for each shift (R5, R6, R7, R9).
   task automatic t_sweep_shifts;
      logic [63:0] pats [3] = '{64'h8000_0000_0000_0001,
                                64'hF0E1_D2C3_B4A5_9687,
                                64'h7FFF_FFFF_FFFF_FFFE};
      for (int p = 0; p < 3; p++)
         for (int n = 0; n < 64; n++) begin
            apply(2'b00, pats[p], 32'(n), 8'h00, ref_out(2'b00, pats[p], n), "R5 lsr");
            apply(2'b01, pats[p], 32'(n), 8'h00, ref_out(2'b01, pats[p], n), "R6 asr");
            apply(2'b10, pats[p], 32'(n), 8'h00, ref_out(2'b10, pats[p], n), "R7 lsl");
         end
   endtask

   // Every rotate count (R8).
   task automatic t_sweep_rotate;
      logic [63:0] d = 64'h0123_4567_89AB_CDEF;
      for (int n = 0; n < 64; n++)
         apply(2'b11, d, 32'h0, 8'(n), ref_out(2'b11, d, n), "R8 ror");
   endtask

   // Zero count passes through on every op (R4).
   task automatic t_zero_count;
      logic [63:0] d = 64'hDEAD_BEEF_CAFE_F00D;
      for (int op = 0; op < 4; op++)
         apply(2'(op), d, 32'h0, 8'h0, d, "R4 zero count");
   endtask

   // Upper count bits are masked off (R1, R2).
   task automatic t_upper_bits;
      logic [63:0] d = 64'h8421_0000_1248_FFFF;
      apply(2'b00, d, 32'hFFFF_FFC5, 8'h0, ref_out(2'b00, d, 5),  "R1 lsr high bits");
      apply(2'b01, d, 32'h0000_0040, 8'h0, d,                     "R1 asr count 64 wraps");
      apply(2'b10, d, 32'h8000_007F, 8'h0, ref_out(2'b10, d, 63), "R1 lsl high bits");
      apply(2'b11, d, 32'h0,         8'hC3, ref_out(2'b11, d, 3), "R2 ror imm high bits");
      apply(2'b11, d, 32'h0,         8'h40, d,                    "R2 ror imm 64 wraps");
   endtask

   // Each op uses only its own count source (R2, R3).
   task automatic t_source_select;
      logic [63:0] d = 64'hA5A5_0000_FFFF_1234;
      apply(2'b11, d, 32'h0000_0011, 8'h04, ref_out(2'b11, d, 4),  "R2 ror ignores reg_count");
      apply(2'b11, d, 32'hFFFF_FFFF, 8'h00, d,                     "R2 ror ignores reg_count zero imm");
      apply(2'b00, d, 32'h0000_0008, 8'h3F, ref_out(2'b00, d, 8),  "R3 lsr ignores imm");
      apply(2'b01, d, 32'h0000_0000, 8'h21, d,                     "R3 asr ignores imm");
      apply(2'b10, d, 32'h0000_0002, 8'hFF, ref_out(2'b10, d, 2),  "R3 lsl ignores imm");
   endtask

   // Sign fill for both top-bit values (R6).
   task automatic t_sign_fill;
      apply(2'b01, 64'h8000_0000_0000_0000, 32'd63, 8'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 negative fill");
      apply(2'b01, 64'h7FFF_FFFF_FFFF_FFFF, 32'd63, 8'h0, 64'h0, "R6 positive fill");
      apply(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 32'd60, 8'h0, 64'hF, "R5 zero fill");
      apply(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 32'd60, 8'h0, 64'hF000_0000_0000_0000, "R7 zero fill");
   endtask

   initial begin
      op_sel = 2'b00; data_in = '0; reg_count = '0; imm_count = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_zero_count();
      t_sweep_shifts();
      t_sweep_rotate();
      t_upper_bits();
      t_source_select();
      t_sign_fill();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule